// File: doc/BRIEF.md
# Link Integrity Monitor for a Twisted-Pair Transceiver

This block decides whether a 10BASE-T twisted-pair link is usable. An upstream receiver front end qualifies incoming link pulses by amplitude and reports each one as a one-cycle strobe. The strobe carries a polarity bit and a flag that says whether the pulse width fell inside the 60 to 200 ns window. The block also sees a flag for valid receive packet activity. From these it keeps a fail/pass link state. In fail it holds the transmit, receive, loopback and collision functions disabled and leaves the link LED dark.

To leave fail, the link needs valid data or an unbroken run of same-polarity qualified pulses. Once in pass, the link is kept alive by data or by pulses of the polarity that was learned. If both are missing for a programmable number of timebase ticks, the block falls back to fail. A strap input bypasses the decision so the data functions stay enabled, and a loopback-test input forces pass. A separate generator emits a link pulse request at a fixed tick interval whenever the transmit side is idle, regardless of the link state.

All timing uses a slow timebase strobe `tick_i`, for example 1 ms. The loss window and the beat interval are therefore parameters counted in ticks.

Top module: `link_integrity_fsm`

## Requirements
- R1: After reset, `link_pass_o` is 0, `link_led_no` is 1, `link_pulse_o` is 0 and `data_en_o` equals `lt_disable_i`.
- R2: In fail, `data_en_o` is 0 (unless the strap is set) and `link_led_no` is 1. In pass, `data_en_o` is 1 and `link_led_no` is 0.
- R3: A pulse is qualified when `pulse_i` and `width_ok_i` are both high. Its polarity is `pulse_neg_i` (0 positive, 1 negative). In fail, the PASS_COUNT-th consecutive qualified pulse of one polarity (default 6) sets `link_pass_o` in the cycle after its strobe. One pulse fewer leaves the link in fail.
- R4: In fail, a qualified pulse whose polarity differs from the current run restarts the run at a count of one.
- R5: A strobe with `width_ok_i` low is ignored. It neither counts toward a run nor breaks one.
- R6: In fail, `rx_data_i` high sets `link_pass_o` in the next cycle.
- R7: In pass, only qualified pulses of the locked polarity refresh the loss window. The locked polarity is that of the run when entry was by pulses; otherwise it is the polarity of the most recent qualified pulse seen in fail, positive after reset. Pulses of the other polarity have no effect.
- R8: In pass, `rx_data_i`, an accepted pulse or `loop_force_i` restarts the loss window. Once LOSS_TICKS ticks have passed with no restart, `link_pass_o` is 0 in the cycle after the last of those ticks.
- R9: `lt_disable_i` high holds `data_en_o` at 1 whatever the link state.
- R10: While `tx_idle_i` is high, `link_pulse_o` is high for one cycle after every BEAT_TICKS-th tick. A low `tx_idle_i` restarts the interval. Neither the link state nor the strap affects this.
- R11: `loop_force_i` high sets `link_pass_o` in the next cycle and keeps it there for as long as it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timebase strobe, one cycle per tick |
| pulse_i | input | 1 | Link pulse detected strobe |
| pulse_neg_i | input | 1 | Polarity of the pulse, 1 = negative |
| width_ok_i | input | 1 | Pulse width within the valid window |
| rx_data_i | input | 1 | Valid receive packet activity |
| tx_idle_i | input | 1 | Transmit side idle |
| lt_disable_i | input | 1 | Strap: bypass the link test |
| loop_force_i | input | 1 | Loopback test, force pass |
| link_pass_o | output | 1 | Link is in pass |
| data_en_o | output | 1 | Enable for transmit, receive, loopback and collision |
| link_led_no | output | 1 | Link LED, active low |
| link_pulse_o | output | 1 | Request to send one link pulse |

## Verification
The assertions assume that `tick_i` and `pulse_i` are one-cycle strobes. They also assume that a state change is caused only by a strobe, by data or by the force input in the cycle before it. A pass-to-fail drop must therefore follow a tick that arrived with no data and no force. The bench respects these assumptions: it raises every strobe for exactly one clock and clears it before the next. It never raises a tick and a pulse in the same cycle, and it changes each level input only between strobes.

// File: rtl/link_pkg.sv
package link_pkg;
  typedef enum logic {
    ST_FAIL = 1'b0,
    ST_PASS = 1'b1
  } link_state_e;
endpackage

// File: rtl/link_run_cnt.sv
// Counts consecutive same-polarity qualified pulses while in fail.
module link_run_cnt #(
  parameter int unsigned PASS_COUNT = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic pulse_v_i,
  input  logic pol_i,
  output logic hit_o,
  output logic run_pol_o
);
  localparam int unsigned RunW = $clog2(PASS_COUNT + 1);
  localparam logic [RunW-1:0] RunLast = RunW'(PASS_COUNT - 1);

  logic [RunW-1:0] cnt_q;
  logic            pol_q;
  logic            same;

  assign same      = (cnt_q == '0) || (pol_i == pol_q);
  assign hit_o     = pulse_v_i && same && (cnt_q == RunLast);
  assign run_pol_o = pol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pol_q <= 1'b0;
    end else begin
      if (pulse_v_i) pol_q <= pol_i;
      if (clr_i) cnt_q <= '0;
      else if (pulse_v_i) cnt_q <= same ? cnt_q + RunW'(1) : RunW'(1);
    end
  end
endmodule

// File: rtl/link_loss_timer.sv
// Loss window in ticks, active only in pass.
module link_loss_timer #(
  parameter int unsigned LOSS_TICKS = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic refresh_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int unsigned LossW = $clog2(LOSS_TICKS);
  localparam logic [LossW-1:0] LossLast = LossW'(LOSS_TICKS - 1);

  logic [LossW-1:0] cnt_q;

  assign expire_o = en_i && !refresh_i && tick_i && (cnt_q == LossLast);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!en_i || refresh_i) cnt_q <= '0;
    else if (tick_i && cnt_q != LossLast) cnt_q <= cnt_q + LossW'(1);
  end
endmodule

// File: rtl/link_beat_gen.sv
// Periodic link pulse request during transmit idle.
module link_beat_gen #(
  parameter int unsigned BEAT_TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic tx_idle_i,
  output logic beat_o
);
  localparam int unsigned BeatW = $clog2(BEAT_TICKS);
  localparam logic [BeatW-1:0] BeatLast = BeatW'(BEAT_TICKS - 1);

  logic [BeatW-1:0] cnt_q;
  logic             wrap;

  assign wrap = tx_idle_i && tick_i && (cnt_q == BeatLast);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      beat_o <= 1'b0;
    end else begin
      beat_o <= wrap;
      if (!tx_idle_i || wrap) cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + BeatW'(1);
    end
  end
endmodule

// File: rtl/link_integrity_fsm.sv
module link_integrity_fsm
  import link_pkg::*;
#(
  parameter int unsigned PASS_COUNT = 6,
  parameter int unsigned LOSS_TICKS = 100,
  parameter int unsigned BEAT_TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic pulse_i,
  input  logic pulse_neg_i,
  input  logic width_ok_i,
  input  logic rx_data_i,
  input  logic tx_idle_i,
  input  logic lt_disable_i,
  input  logic loop_force_i,
  output logic link_pass_o,
  output logic data_en_o,
  output logic link_led_no,
  output logic link_pulse_o
);
  link_state_e state_q, state_d;
  logic lock_pol_q;
  logic pass_now, pulse_v, accept, hit, run_pol, expire, refresh;

  assign pass_now = (state_q == ST_PASS);
  assign pulse_v  = pulse_i && width_ok_i;
  assign accept   = pass_now && pulse_v && (pulse_neg_i == lock_pol_q);
  assign refresh  = rx_data_i || accept || loop_force_i;

  link_run_cnt #(.PASS_COUNT(PASS_COUNT)) i_run (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (pass_now),
    .pulse_v_i (pulse_v && !pass_now),
    .pol_i     (pulse_neg_i),
    .hit_o     (hit),
    .run_pol_o (run_pol)
  );

  link_loss_timer #(.LOSS_TICKS(LOSS_TICKS)) i_loss (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (pass_now),
    .refresh_i (refresh),
    .tick_i    (tick_i),
    .expire_o  (expire)
  );

  link_beat_gen #(.BEAT_TICKS(BEAT_TICKS)) i_beat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .tx_idle_i (tx_idle_i),
    .beat_o    (link_pulse_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FAIL: if (loop_force_i || rx_data_i || hit) state_d = ST_PASS;
      ST_PASS: if (expire) state_d = ST_FAIL;
      default: state_d = ST_FAIL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_FAIL;
      lock_pol_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (!pass_now && state_d == ST_PASS) lock_pol_q <= hit ? pulse_neg_i : run_pol;
    end
  end

  assign link_pass_o = pass_now;
  assign data_en_o   = pass_now || lt_disable_i;
  assign link_led_no = !pass_now;
endmodule

// File: rtl/link_integrity_chk.sv
module link_integrity_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic pulse_i,
  input logic width_ok_i,
  input logic rx_data_i,
  input logic tx_idle_i,
  input logic lt_disable_i,
  input logic loop_force_i,
  input logic link_pass_o,
  input logic data_en_o,
  input logic link_led_no,
  input logic link_pulse_o
);
  assert_reset_fail_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> !link_pass_o);

  assert_fail_outputs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_pass_o |-> (link_led_no && (data_en_o == lt_disable_i)));

  assert_pass_outputs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_pass_o |-> (!link_led_no && data_en_o));

  assert_entry_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_pass_o) |-> $past(rx_data_i || loop_force_i || (pulse_i && width_ok_i)));

  assert_data_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_data_i |=> link_pass_o);

  assert_drop_on_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(link_pass_o) |-> $past(tick_i && !rx_data_i && !loop_force_i));

  assert_strap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lt_disable_i |-> data_en_o);

  assert_beat_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_pulse_o |-> $past(tx_idle_i && tick_i));

  assert_beat_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_pulse_o |=> !link_pulse_o);

  assert_force_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_force_i |=> link_pass_o);
endmodule

bind link_integrity_fsm link_integrity_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .pulse_i      (pulse_i),
  .width_ok_i   (width_ok_i),
  .rx_data_i    (rx_data_i),
  .tx_idle_i    (tx_idle_i),
  .lt_disable_i (lt_disable_i),
  .loop_force_i (loop_force_i),
  .link_pass_o  (link_pass_o),
  .data_en_o    (data_en_o),
  .link_led_no  (link_led_no),
  .link_pulse_o (link_pulse_o)
);

// File: tb/test_link_integrity_fsm.sv
`timescale 1ns/1ps
module test_link_integrity_fsm;
  localparam int unsigned PassCount = 6;
  localparam int unsigned LossTicks = 8;
  localparam int unsigned BeatTicks = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 0, pulse_i = 0, pulse_neg_i = 0, width_ok_i = 0;
  logic rx_data_i = 0, tx_idle_i = 0, lt_disable_i = 0, loop_force_i = 0;
  logic link_pass_o, data_en_o, link_led_no, link_pulse_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  link_integrity_fsm #(
    .PASS_COUNT(PassCount), .LOSS_TICKS(LossTicks), .BEAT_TICKS(BeatTicks)
  ) i_link_integrity_fsm (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .pulse_i(pulse_i),
    .pulse_neg_i(pulse_neg_i), .width_ok_i(width_ok_i), .rx_data_i(rx_data_i),
    .tx_idle_i(tx_idle_i), .lt_disable_i(lt_disable_i), .loop_force_i(loop_force_i),
    .link_pass_o(link_pass_o), .data_en_o(data_en_o), .link_led_no(link_led_no),
    .link_pulse_o(link_pulse_o)
  );

  // {count[3:0], polarity bits[7:0], width-ok bits[7:0], expected pass}
  localparam logic [20:0] VEC [8] = '{
    {4'd6, 8'h00, 8'h3F, 1'b1},  // R3 six positive
    {4'd5, 8'h00, 8'h1F, 1'b0},  // R3 five positive
    {4'd6, 8'h3F, 8'h3F, 1'b1},  // R3 six negative
    {4'd7, 8'h7E, 8'h7F, 1'b1},  // R4 one positive then six negative
    {4'd8, 8'hF8, 8'hFF, 1'b0},  // R4 three positive then five negative
    {4'd7, 8'h08, 8'h77, 1'b1},  // R5 bad-width opposite pulse inside run
    {4'd6, 8'h00, 8'h3B, 1'b0},  // R5 bad-width pulse not counted
    {4'd7, 8'h00, 8'h7F, 1'b1}   // R3 seventh pulse after pass
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    step();
    rst_ni = 1'b1;
    step();
  endtask

  task automatic strobe(input logic neg, input logic wok);
    pulse_i = 1'b1; pulse_neg_i = neg; width_ok_i = wok;
    step();
    pulse_i = 1'b0; width_ok_i = 1'b0;
  endtask

  task automatic do_tick();
    tick_i = 1'b1;
    step();
    tick_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) do_tick();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #1;
    step();
    rst_ni = 1'b1;
    step();
    // R1 reset state
    check("R1 pass", link_pass_o, 1'b0);
    check("R1 led", link_led_no, 1'b1);
    check("R1 en", data_en_o, 1'b0);
    check("R1 beat", link_pulse_o, 1'b0);

    // Pulse run table
    for (int i = 0; i < 8; i++) begin
      logic [3:0] n;
      logic [7:0] pol, wok;
      logic exp;
      string req;
      {n, pol, wok, exp} = VEC[i];
      req = (i < 3 || i == 7) ? "R3" : (i < 5) ? "R4" : "R5";
      do_reset();
      for (int k = 0; k < int'(n); k++) strobe(pol[k], wok[k]);
      check(req, link_pass_o, exp);
    end

    // R3: pass asserted exactly after sixth strobe
    do_reset();
    for (int k = 0; k < 5; k++) strobe(1'b0, 1'b1);
    check("R3 before sixth", link_pass_o, 1'b0);
    strobe(1'b0, 1'b1);
    check("R3 on sixth", link_pass_o, 1'b1);
    check("R2 pass led", link_led_no, 1'b0);
    check("R2 pass en", data_en_o, 1'b1);

    // R9 strap in fail
    do_reset();
    lt_disable_i = 1'b1;
    step();
    check("R9 strap en", data_en_o, 1'b1);
    check("R9 still fail", link_pass_o, 1'b0);
    lt_disable_i = 1'b0;
    step();
    check("R2 fail en", data_en_o, 1'b0);

    // R6 data entry, R8 loss window
    rx_data_i = 1'b1;
    step();
    rx_data_i = 1'b0;
    check("R6 data entry", link_pass_o, 1'b1);
    ticks(LossTicks - 1);
    check("R8 before window", link_pass_o, 1'b1);
    do_tick();
    check("R8 window expired", link_pass_o, 1'b0);
    check("R2 fail led", link_led_no, 1'b1);
    check("R2 fail en", data_en_o, 1'b0);

    // R7 opposite polarity ignored in pass
    do_reset();
    for (int k = 0; k < 6; k++) strobe(1'b0, 1'b1);
    ticks(LossTicks - 1);
    strobe(1'b1, 1'b1);
    check("R7 opposite pulse no entry change", link_pass_o, 1'b1);
    do_tick();
    check("R7 opposite pulse ignored", link_pass_o, 1'b0);

    // R7 locked polarity refreshes
    do_reset();
    for (int k = 0; k < 6; k++) strobe(1'b1, 1'b1);
    ticks(LossTicks - 1);
    strobe(1'b1, 1'b1);
    ticks(LossTicks - 1);
    check("R7 locked pulse refresh", link_pass_o, 1'b1);
    do_tick();
    check("R8 after refresh", link_pass_o, 1'b0);

    // R7 bad width pulse in pass does not refresh
    do_reset();
    for (int k = 0; k < 6; k++) strobe(1'b0, 1'b1);
    ticks(LossTicks - 1);
    strobe(1'b0, 1'b0);
    do_tick();
    check("R7 bad width no refresh", link_pass_o, 1'b0);

    // R11 loopback force
    do_reset();
    loop_force_i = 1'b1;
    step();
    check("R11 forced pass", link_pass_o, 1'b1);
    ticks(3 * LossTicks);
    check("R11 held pass", link_pass_o, 1'b1);
    loop_force_i = 1'b0;
    ticks(LossTicks - 1);
    check("R8 after force release", link_pass_o, 1'b1);
    do_tick();
    check("R8 drop after force", link_pass_o, 1'b0);

    // R10 beat generation, in fail with strap set
    do_reset();
    lt_disable_i = 1'b1;
    tx_idle_i = 1'b1;
    step();
    for (int k = 1; k <= 2 * BeatTicks; k++) begin
      do_tick();
      check("R10 beat", link_pulse_o, (k % BeatTicks) == 0);
      if ((k % BeatTicks) == 0) begin
        step();
        check("R10 beat single", link_pulse_o, 1'b0);
      end
    end
    ticks(2);
    tx_idle_i = 1'b0;
    step();
    tx_idle_i = 1'b1;
    ticks(BeatTicks - 1);
    check("R10 restart after busy", link_pulse_o, 1'b0);
    do_tick();
    check("R10 beat after restart", link_pulse_o, 1'b1);
    tx_idle_i = 1'b0;
    lt_disable_i = 1'b0;
    ticks(BeatTicks);
    check("R10 no beat when busy", link_pulse_o, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule